// File: doc/BRIEF.md
# Fractional Rate Request Pacer

This block produces single-cycle request pulses at an average rate equal to a programmable fraction X/Y of its own clock. It is meant to sit in front of the transfer-request input of a DMA channel. The channel then moves one item per pulse, for example one sample per pulse into a converter's serial port, at a steady audio-like rate that is derived directly from the system clock.

Both X and Y are held in a single configuration word and are loaded through a one-cycle write strobe. On every clock the block adds X to an internal remainder. When the remainder reaches or passes Y, it subtracts Y and fires a request. The result is the evenly spread pulse train of a fractional divider, and no integer division is needed.

A ratio of one or more gives a request on every clock. A zero in either field stops the requests. Each write restarts the pattern from a zero remainder, so the phase after a write does not depend on any earlier setting.

Top module: `pacer_frac`

## Requirements
- R1: The configuration word carries the numerator X in bits 31:16 and the denominator Y in bits 15:0. Both are loaded together on a clock edge where `cfg_we` is high.
- R2: While reset is held, and after it is released, `req_pulse` is low, the stored X and Y are zero, and no requests are produced until a write.
- R3: When the stored X is zero or the stored Y is zero, `req_pulse` stays low.
- R4: When X and Y are both nonzero and X is greater than or equal to Y, `req_pulse` is high in every cycle from the second cycle after the write onward.
- R5: When 0 < X < Y, evaluation n after a write (n = 1, 2, ...) produces a pulse exactly when floor(n·X/Y) exceeds floor((n−1)·X/Y). This holds for all field values up to 0xFFFF.
- R6: When 0 < X < Y, every run of Y evaluations after a write holds exactly X pulses, and no two pulses are closer than floor(Y/X) cycles. For example, word 0x0017FFFF gives 23 pulses per 65535 cycles.
- R7: A write clears the internal remainder, and `req_pulse` is low in the cycle after the write edge. Evaluation 1 of the new ratio shows on `req_pulse` one cycle after that.
- R8: A write in the middle of a running pattern discards the old phase. The following pulses match R5 counted from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: X in 31:16, Y in 15:0 |
| req_pulse | output | 1 | Registered transfer-request pulse |

## Verification
A remainder that is corrupted, or that is not cleared on a write, moves the pulse phase. That shows at `req_pulse` within one evaluation, because the bench predicts every cycle from floor(n·X/Y) counted from the write. A remainder that overflows its width, or a wrong comparison with Y, shows up as a missing or extra pulse long before a full period ends. The large-field ratios exercise the carry into the extra bit. Swapped fields or a dropped saturation for ratios at or above one change the pulse count on the very first evaluations after the write.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    // Operating mode derived from the stored ratio
    typedef enum logic [1:0] {
        PACE_IDLE = 2'd0,   // no requests
        PACE_FRAC = 2'd1,   // fractional accumulation
        PACE_FULL = 2'd2    // request every clock
    } pace_mode_e;

    function automatic pace_mode_e pick_mode(input logic num_zero,
                                             input logic den_zero,
                                             input logic num_ge_den);
        pace_mode_e m;
        if (num_zero || den_zero)
            m = PACE_IDLE;
        else if (num_ge_den)
            m = PACE_FULL;
        else
            m = PACE_FRAC;
        return m;
    endfunction

endpackage

// File: rtl/pacer_cfg_reg.sv
module pacer_cfg_reg
    import pacer_pkg::*;
#(
    parameter int RATIO_W = 16,
    localparam int CFG_W  = 2 * RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [RATIO_W-1:0] num,
    output logic [RATIO_W-1:0] den,
    output pace_mode_e         mode
);

    typedef struct packed {
        logic [RATIO_W-1:0] num;   // upper half of the word
        logic [RATIO_W-1:0] den;   // lower half of the word
    } ratio_t;

    ratio_t ratio_q;

    always_ff @(posedge clk) begin
        if (rst)
            ratio_q <= '0;
        else if (cfg_we)
            ratio_q <= ratio_t'(cfg_wdata);
    end

    assign num  = ratio_q.num;
    assign den  = ratio_q.den;
    assign mode = pick_mode(ratio_q.num == '0, ratio_q.den == '0,
                            ratio_q.num >= ratio_q.den);

endmodule

// File: rtl/pacer_accum.sv
module pacer_accum
    import pacer_pkg::*;
#(
    parameter int RATIO_W = 16,
    localparam int SUM_W  = RATIO_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  pace_mode_e         mode,
    input  logic [RATIO_W-1:0] num,
    input  logic [RATIO_W-1:0] den,
    output logic               fire
);

    logic [RATIO_W-1:0] acc_q;
    logic [SUM_W-1:0]   sum;
    logic [SUM_W-1:0]   sum_sel;
    logic               reach;

    assign sum     = {1'b0, acc_q} + {1'b0, num};
    assign reach   = sum >= {1'b0, den};
    assign sum_sel = reach ? (sum - {1'b0, den}) : sum;
    assign fire    = (mode == PACE_FULL) || ((mode == PACE_FRAC) && reach);

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (mode == PACE_FRAC)
            acc_q <= sum_sel[RATIO_W-1:0];
        else
            acc_q <= '0;
    end

    // R5
    acc_below_den_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PACE_FRAC) |-> (acc_q < den));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PACE_FRAC) |-> !sum_sel[RATIO_W]);

endmodule

// File: rtl/pacer_req_out.sv
module pacer_req_out (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic fire,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            req <= 1'b0;
        else
            req <= fire;
    end

    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !req);

endmodule

// File: rtl/pacer_frac.sv
module pacer_frac
    import pacer_pkg::*;
#(
    parameter int RATIO_W = 16,
    localparam int CFG_W  = 2 * RATIO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             req_pulse
);

    logic [RATIO_W-1:0] num;
    logic [RATIO_W-1:0] den;
    pace_mode_e         mode;
    logic               fire;

    pacer_cfg_reg #(.RATIO_W(RATIO_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .num       (num),
        .den       (den),
        .mode      (mode)
    );

    pacer_accum #(.RATIO_W(RATIO_W)) u_accum (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_we),
        .mode (mode),
        .num  (num),
        .den  (den),
        .fire (fire)
    );

    pacer_req_out u_out (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_we),
        .fire (fire),
        .req  (req_pulse)
    );

    // R4
    full_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we && mode == PACE_FULL) |=> req_pulse);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PACE_IDLE) |=> !req_pulse);

endmodule

// File: tb/pacer_frac_bench.sv
module pacer_frac_bench;

    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [2*W-1:0] cfg_wdata = '0;
    logic           req_pulse;

    always #5 clk = ~clk;

    pacer_frac u_pacer_frac (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .req_pulse (req_pulse)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 1'b0;
    longint mx = 0, my = 0, mn = 0;
    longint seg_pulses = 0, last_hit = -1, min_gap = 0;

    function automatic logic expect_fire(longint x, longint y, longint n);
        if (x == 0 || y == 0) return 1'b0;
        if (x >= y) return 1'b1;
        return ((n * x) / y) != (((n - 1) * x) / y);
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: req_pulse=%0b expected %0b (eval %0d, X=%0d Y=%0d)",
                     tag, act, exp, mn, mx, my);
        end
    endtask

    task automatic check_num(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d (X=%0d Y=%0d)", tag, act, exp, mx, my);
        end
    endtask

    task automatic write_cfg(int x, int y);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {x[W-1:0], y[W-1:0]};
        @(negedge clk);
        cfg_we     = 1'b0;
        mx = x; my = y; mn = 0;
        seg_pulses = 0; last_hit = -1; min_gap = 64'd1 << 40;
        // R7: output low right after the write edge
        check_bit("R7", req_pulse, 1'b0);
    endtask

    task automatic run(int cycles, string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            mn++;
            check_bit(tag, req_pulse, expect_fire(mx, my, mn));
            if (req_pulse) begin
                seg_pulses++;
                if (last_hit >= 0 && (mn - last_hit) < min_gap) min_gap = mn - last_hit;
                last_hit = mn;
            end
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    initial begin
        // R2: low during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_bit("R2", req_pulse, 1'b0);
        end
        rst = 1'b0;
        mx = 0; my = 0; mn = 0;
        run(20, "R2");

        // R3: zero numerator, zero denominator
        write_cfg(0, 5);
        run(30, "R3");
        write_cfg(3, 0);
        run(30, "R3");

        // R5/R6: 3/8 over four periods; R1 field order
        write_cfg(3, 8);
        run(32, "R5");
        check_num("R1", seg_pulses, 12);
        check_num("R6", min_gap >= 2 ? 1 : 0, 1);

        // R4: equal and greater ratios
        write_cfg(5, 5);
        run(20, "R4");
        check_num("R4", seg_pulses, 20);
        write_cfg(9, 4);
        run(20, "R4");

        // R8: restart mid-stream
        write_cfg(7, 10);
        run(13, "R8");
        write_cfg(2, 7);
        run(35, "R8");
        check_num("R8", seg_pulses, 10);

        // R5: wide field values exercise the carry bit
        write_cfg(16'hFFFE, 16'hFFFF);
        run(300, "R5");
        write_cfg(16'hFFFF, 16'hFFFE);
        run(20, "R4");
        write_cfg(16'h8001, 16'hFFFF);
        run(300, "R5");

        // R6: audio-rate word 0x0017FFFF, one full period
        write_cfg(16'h0017, 16'hFFFF);
        run(65535, "R6");
        check_num("R6", seg_pulses, 23);
        check_num("R6", min_gap >= (65535 / 23) ? 1 : 0, 1);

        summary();
    end

endmodule